// File: doc/BRIEF.md
# Serial Port Status Flag Clear Sequencer

This block holds the nine status flags of a serial port and decides when each one may be cleared. The transmitter and receiver raise flags with one-cycle set pulses. Software never clears a flag directly. It must first read the 16-bit status word while the flag is set, which arms that flag. It must then access the data register. A data read clears armed receive flags, and a data write clears armed transmit flags.

Arming is held per flag. A flag whose set event comes after the status read is therefore not disarmed by mistake, and it survives the following data access. The status word and an interrupt request are presented continuously. The interrupt request is the OR of the set flags that are individually enabled.

A read strobe marked as long covers the status and data registers in one access. It clears the receive flags that are set at that moment and arms the transmit flags for a later data write. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `sflag_top`

## Requirements
- R1: After reset the status word is 0x0180: both transmit flags are 1 and all receive flags are 0.
- R2: Status bit positions are: 8 transmit-register-empty, 7 transmit-complete, 6 receive-full, 5 receiver-active, 4 line-idle, 3 overrun, 2 noise, 1 framing, 0 parity. Bits 15 to 9 always read 0.
- R3: A set pulse on `set_pulse[i]` makes status bit i read 1 from the next clock edge, whatever the bus is doing.
- R4: A receive flag (bits 6 to 0) that is set during a status read (`bus_sel`=0) is cleared by the next data read (`bus_sel`=1).
- R5: A transmit flag (bits 8 and 7) that is set during a status read is cleared by the next data write. A data read leaves transmit flags unchanged, and a data write leaves receive flags unchanged.
- R6: A flag whose set pulse arrives after the status read is not cleared by the data access that follows.
- R7: A data access clears only flags armed by a status read since the last matching data access. Without such a read it has no effect.
- R8: A status read with either byte lane enabled arms flags in both bytes. An access with `bus_be`=0 is ignored.
- R9: A long read (`bus_rd` with `bus_long`) clears every receive flag set at that cycle. It leaves transmit flags set but armed for the next data write.
- R10: When a set pulse and a clearing access hit the same flag in the same cycle, the flag stays set and its arming is discarded.
- R11: `irq` is 1 exactly when some status bit i is 1 and `irq_en[i]` is 1.
- R12: A write to the status register changes no flag and arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_long | input | 1 | Read spans the status and data registers |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_be | input | 2 | Byte lane enables |
| set_pulse | input | 9 | Hardware set pulses, one per flag |
| irq_en | input | 9 | Per-flag interrupt enables |
| stat_word | output | 16 | Current status word |
| irq | output | 1 | Interrupt request |

## Verification
Every flag change takes effect at the first clock edge after the strobe or pulse cycle. Each stimulus is driven on a falling edge and held for one cycle, so the bench checks the status word at the next falling edge. The interrupt request follows the flags and enables with no register in between. After an enable change the bench waits a short delay within the same cycle and then samples it. Reset release takes two synchronizer edges, so the first check waits three cycles after `rst_n` rises.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int FLAG_W = 9;
  localparam int STAT_W = 16;
  localparam int BE_W   = 2;
  localparam logic [FLAG_W-1:0] TX_MASK     = 9'h180;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = 9'h180;
  localparam int PAD_W = STAT_W - FLAG_W;
endpackage

// File: rtl/sflag_rst_sync.sv
module sflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sflag_bus_dec.sv
module sflag_bus_dec #(
  parameter int BE_W = 2
) (
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic            bus_long,
  input  logic            bus_sel,
  input  logic [BE_W-1:0] bus_be,
  output logic            stat_rd,
  output logic            long_rd,
  output logic            dat_rd,
  output logic            dat_wr
);
  logic lane_any;
  logic rd_ok;
  logic wr_ok;

  always_comb begin
    lane_any = |bus_be;
    rd_ok    = bus_rd & lane_any;
    wr_ok    = bus_wr & ~bus_rd & lane_any;
    long_rd  = rd_ok & bus_long;
    stat_rd  = rd_ok & (bus_long | ~bus_sel);
    dat_rd   = rd_ok & ~bus_long & bus_sel;
    dat_wr   = wr_ok & bus_sel;
  end
endmodule

// File: rtl/sflag_cell.sv
module sflag_cell #(
  parameter bit IS_TX   = 1'b0,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_p,
  input  logic stat_rd,
  input  logic long_rd,
  input  logic dat_rd,
  input  logic dat_wr,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic consume, clr_hit, upd_en;

  always_comb begin
    if (IS_TX) begin
      consume = dat_wr;
      clr_hit = arm_q & dat_wr;
    end else begin
      consume = dat_rd;
      clr_hit = (arm_q & dat_rd) | (flag_q & long_rd);
    end
    upd_en = set_p | stat_rd | long_rd | dat_rd | dat_wr;

    flag_d = flag_q;
    if (clr_hit) flag_d = 1'b0;
    if (set_p)   flag_d = 1'b1;

    arm_d = arm_q;
    if (consume) arm_d = 1'b0;
    if (stat_rd) arm_d = flag_q & (IS_TX | ~long_rd);
    if (set_p)   arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;

  p_set_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_p |=> flag_q);
  p_rise_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_p));
  p_rx_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_TX && $fell(flag_q)) |-> ($past(dat_rd) || $past(long_rd)));
  p_tx_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && $fell(flag_q)) |-> $past(dat_wr));
  p_arm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q);
endmodule

// File: rtl/sflag_top.sv
module sflag_top
  import sflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_long,
  input  logic              bus_sel,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [FLAG_W-1:0] set_pulse,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  logic rst_i_n;
  logic stat_rd, long_rd, dat_rd, dat_wr;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] armed;

  sflag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sflag_bus_dec #(.BE_W(BE_W)) u_dec (
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_long (bus_long),
    .bus_sel  (bus_sel),
    .bus_be   (bus_be),
    .stat_rd  (stat_rd),
    .long_rd  (long_rd),
    .dat_rd   (dat_rd),
    .dat_wr   (dat_wr)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    sflag_cell #(
      .IS_TX   (TX_MASK[i]),
      .RST_VAL (RESET_FLAGS[i])
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .set_p   (set_pulse[i]),
      .stat_rd (stat_rd),
      .long_rd (long_rd),
      .dat_rd  (dat_rd),
      .dat_wr  (dat_wr),
      .flag_o  (flags[i]),
      .armed_o (armed[i])
    );
  end

  always_comb begin
    stat_word = {{PAD_W{1'b0}}, flags};
    irq       = |(flags & irq_en);
  end

  p_long_rx_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (long_rd && set_pulse == '0) |=> (flags & ~TX_MASK) == '0);
  p_swrite_r12: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && !bus_rd && !bus_sel && set_pulse == '0) |=> $stable(flags));
endmodule

// File: tb/sflag_top_test.sv
module sflag_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_rd, bus_wr, bus_long, bus_sel;
  logic [1:0]  bus_be;
  logic [8:0]  set_pulse, irq_en;
  logic [15:0] stat_word;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sflag_top uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_long(bus_long), .bus_sel(bus_sel), .bus_be(bus_be),
    .set_pulse(set_pulse), .irq_en(irq_en), .stat_word(stat_word), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, got, exp);
    end
  endtask

  task automatic op(input bit rd, input bit wr, input bit lng, input bit sel,
                    input logic [1:0] be, input logic [8:0] pls);
    bus_rd = rd; bus_wr = wr; bus_long = lng; bus_sel = sel; bus_be = be;
    set_pulse = pls;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_long = 0; bus_sel = 0; bus_be = 0;
    set_pulse = '0;
  endtask

  task automatic pulse(input logic [8:0] m);   op(0, 0, 0, 0, 2'b00, m); endtask
  task automatic srd(input logic [1:0] be);    op(1, 0, 0, 0, be, '0); endtask
  task automatic drd(input logic [1:0] be);    op(1, 0, 0, 1, be, '0); endtask
  task automatic dwr();                        op(0, 1, 0, 1, 2'b11, '0); endtask

  task automatic t_reset();
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_long = 0; bus_sel = 0;
    bus_be = 0; set_pulse = 0; irq_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", stat_word, 16'h0180);
    chk("R11 irq masked at reset", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_set_layout();
    pulse(9'h041);
    chk("R3 set rx-full and parity", stat_word, 16'h01C1);
    pulse(9'h1FF);
    chk("R2 all flags, upper bits zero", stat_word, 16'h01FF);
    srd(2'b11); drd(2'b11);
    chk("R4 rx flags cleared", stat_word, 16'h0180);
  endtask

  task automatic t_tx_clear();
    pulse(9'h040);
    srd(2'b11);
    dwr();
    chk("R5 write clears tx only", stat_word, 16'h0040);
    drd(2'b11);
    chk("R4 armed rx cleared by read", stat_word, 16'h0000);
  endtask

  task automatic t_no_arm();
    pulse(9'h008);
    drd(2'b11);
    chk("R7 read without status read", stat_word, 16'h0008);
    pulse(9'h100);
    dwr();
    chk("R7 write without status read", stat_word, 16'h0108);
    drd(2'b11);
    chk("R5 read leaves tx", stat_word, 16'h0108);
  endtask

  task automatic t_late();
    srd(2'b11);
    pulse(9'h004);
    drd(2'b11);
    chk("R6 late rx flag survives", stat_word, 16'h0104);
    dwr();
    chk("R6 earlier tx flag cleared", stat_word, 16'h0004);
    srd(2'b11);
    pulse(9'h080);
    dwr();
    chk("R6 late tx flag survives", stat_word, 16'h0084);
    drd(2'b11);
    chk("R4 noise flag cleared", stat_word, 16'h0080);
  endtask

  task automatic t_lanes();
    pulse(9'h002);
    srd(2'b10);
    drd(2'b11);
    chk("R8 upper lane arms low byte", stat_word, 16'h0080);
    srd(2'b01);
    dwr();
    chk("R8 lower lane arms tx", stat_word, 16'h0000);
    pulse(9'h020);
    srd(2'b00);
    drd(2'b11);
    chk("R8 lane-less status read ignored", stat_word, 16'h0020);
    srd(2'b11);
    drd(2'b00);
    chk("R8 lane-less data read ignored", stat_word, 16'h0020);
    drd(2'b11);
    chk("R8 arming kept past ignored access", stat_word, 16'h0000);
  endtask

  task automatic t_long();
    pulse(9'h141);
    op(1, 0, 1, 0, 2'b11, '0);
    chk("R9 long read clears rx", stat_word, 16'h0100);
    dwr();
    chk("R9 long read arms tx", stat_word, 16'h0000);
  endtask

  task automatic t_collide();
    pulse(9'h040);
    srd(2'b11);
    op(1, 0, 0, 1, 2'b11, 9'h040);
    chk("R10 set wins over clear", stat_word, 16'h0040);
    drd(2'b11);
    chk("R10 arming discarded", stat_word, 16'h0040);
    srd(2'b11); drd(2'b11);
    chk("R4 cleared after rearm", stat_word, 16'h0000);
  endtask

  task automatic t_irq();
    irq_en = 9'h040;
    pulse(9'h040);
    chk("R11 enabled flag raises irq", {15'd0, irq}, 16'h0001);
    irq_en = 9'h001;
    #1;
    chk("R11 disabled flag no irq", {15'd0, irq}, 16'h0000);
    irq_en = 9'h000;
    srd(2'b11); drd(2'b11);
    chk("R4 rx-full cleared", stat_word, 16'h0000);
  endtask

  task automatic t_stat_write();
    pulse(9'h010);
    op(0, 1, 0, 0, 2'b11, '0);
    chk("R12 status write no change", stat_word, 16'h0010);
    drd(2'b11);
    chk("R12 status write arms nothing", stat_word, 16'h0010);
  endtask

  initial begin
    t_reset();
    t_set_layout();
    t_tx_clear();
    t_no_arm();
    t_late();
    t_lanes();
    t_long();
    t_collide();
    t_irq();
    t_stat_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule